// File: doc/BRIEF.md
# 132-bit Line Block Encoder and Decoder with Additive Scrambler

This block turns protocol traffic into 132-bit line blocks for a serial lane that carries its clock inside the data, and shifts each block out one bit per clock. Two input channels feed it, each with a valid/ready handshake. One takes a 128-bit data payload with a byte count. The other takes a 32-bit control word. A data block carries its payload through a 23-bit additive scrambler, and any bytes beyond the byte count are cleared first. A control block carries four copies of the control word, two of them inverted, and is never scrambled. When the designated start-of-packet control word is sent, the scrambler restarts from a fixed seed.

The same top level holds the matching receive path. It takes a serial bit stream with a block-start marker, classifies each header while tolerating a single flipped header bit, descrambles data payloads, and recovers control words by a bitwise vote across the four copies. Connecting the line outputs to the receive inputs gives a loopback in which the encoder is checked end to end, with errors injected on the line as needed.

Top module: `blk132_link`

## Requirements
- R1: After reset the line is idle (`line_en` low), `rx_valid` is low, both `ctl_ready` and `dat_ready` are high, and both scramblers hold the seed 0x1DBFBC.
- R2: Each accepted item produces exactly 132 consecutive line bits with `line_en` high and `line_start` high on the first. Block bit 0 goes first. Bits 3:0 hold the header, 4'b0011 for control and 4'b1100 for data, so a control block starts 1,1,0,0 and a data block starts 0,0,1,1. Block bits 131:4 carry payload bits 127:0.
- R3: A control payload is {~w, w, ~w, w} for control word w, so the true copy sits in payload bits 31:0. It is sent without scrambling.
- R4: The scrambler state s[22:0] steps as s <= {s[21:0], s[22]^s[20]^s[15]^s[7]^s[5]^s[1]} (x^23+x^21+x^16+x^8+x^6+x^2+1). Each data payload bit is XORed with s[22] and then the state steps once. The state holds during headers and control blocks, and it is loaded with 0x1DBFBC when the start-of-packet word 0xF0E1D2C3 is accepted as a control block.
- R5: Data payload byte k (bits 8k+7:8k) is sent as supplied when k < `dat_nbytes` and as zero otherwise. A count above 16 acts as 16, and a count of 0 sends an all-zero payload before scrambling.
- R6: A control request takes priority. `dat_ready` is low whenever `ctl_valid` is high. An item is accepted only while idle or on the last bit of the current block, and a block accepted on the last bit starts on the next cycle with no gap.
- R7: The receiver classifies a header within one bit of 4'b0011 as control and within one bit of 4'b1100 as data.
- R8: A header two or more bits from both valid headers sets `rx_err`, clears `rx_is_ctrl`, and leaves the receive scrambler unchanged.
- R9: A received control word is the bitwise vote of the four copies after re-inverting copies 1 and 3. A bit with three or four agreeing copies takes the agreed value. On a two-two tie the bit takes copy 0. A start-of-packet word decoded this way reloads the receive scrambler with the seed.
- R10: `rx_valid` pulses for one cycle, the cycle after the last bit of a block is received. A data block yields the descrambled payload on `rx_payload`, and a flipped line payload bit flips only the same payload bit. `rx_payload` and `rx_ctrl` hold their values between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_valid | input | 1 | Control word offered |
| ctl_ready | output | 1 | Control word taken this cycle if valid |
| ctl_word | input | 32 | Control word |
| dat_valid | input | 1 | Data payload offered |
| dat_ready | output | 1 | Data payload taken this cycle if valid |
| dat_payload | input | 128 | Data payload |
| dat_nbytes | input | 5 | Number of valid low-order payload bytes |
| line_en | output | 1 | A line bit is present this cycle |
| line_start | output | 1 | Current line bit is block bit 0 |
| line_bit | output | 1 | Serial line bit |
| rx_en | input | 1 | A received bit is present this cycle |
| rx_start | input | 1 | Received bit is block bit 0 |
| rx_bit | input | 1 | Received serial bit |
| rx_valid | output | 1 | One-cycle pulse: a block was decoded |
| rx_is_ctrl | output | 1 | Decoded block was control |
| rx_err | output | 1 | Decoded header was unrecognisable |
| rx_payload | output | 128 | Decoded payload (descrambled for data) |
| rx_ctrl | output | 32 | Voted control word |

## Verification
A scrambler state that drifts by even one step on either side is invisible in headers and control blocks. It shows up at the ports as a garbled data payload on the first data block that follows, and it persists until the next start-of-packet word, so a single data block after each control block exposes it within 132 cycles. A bit counter that is off by one shows up in the same block as a shifted header bit or in the spacing between block starts, which must be exactly 132 cycles. A wrong vote or wrong copy inversion appears only when copies disagree, so line errors are injected into chosen copies, including a two-two tie.

// File: rtl/blk132_pkg.sv
package blk132_pkg;

    localparam int HDR_W = 4;
    localparam int SCR_W = 23;

    localparam logic [HDR_W-1:0] HDR_CTRL = 4'b0011;
    localparam logic [HDR_W-1:0] HDR_DATA = 4'b1100;

    typedef enum logic [1:0] {
        HC_DATA = 2'd0,
        HC_CTRL = 2'd1,
        HC_BAD  = 2'd2
    } hdr_class_e;

    // One step of the additive scrambler, x^23+x^21+x^16+x^8+x^6+x^2+1.
    function automatic logic [SCR_W-1:0] scr_step(input logic [SCR_W-1:0] s);
        logic fb;
        fb = s[22] ^ s[20] ^ s[15] ^ s[7] ^ s[5] ^ s[1];
        return {s[SCR_W-2:0], fb};
    endfunction

    // Header classification tolerating one flipped bit.
    function automatic hdr_class_e hdr_classify(input logic [HDR_W-1:0] h);
        int dc;
        int dd;
        dc = $countones(h ^ HDR_CTRL);
        dd = $countones(h ^ HDR_DATA);
        if (dc <= 1)      return HC_CTRL;
        else if (dd <= 1) return HC_DATA;
        else              return HC_BAD;
    endfunction

endpackage

// File: rtl/blk132_enc.sv
module blk132_enc
    import blk132_pkg::*;
#(
    parameter int               CW       = 32,
    parameter logic [SCR_W-1:0] SEED     = 23'h1DBFBC,
    parameter logic [CW-1:0]    SOP_WORD = 32'hF0E1_D2C3,
    localparam int PAY_W  = 4 * CW,
    localparam int BLK_W  = HDR_W + PAY_W,
    localparam int NBYTES = PAY_W / 8,
    localparam int NB_W   = $clog2(NBYTES + 1),
    localparam int CNT_W  = $clog2(BLK_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_valid,
    output logic             ctl_ready,
    input  logic [CW-1:0]    ctl_word,
    input  logic             dat_valid,
    output logic             dat_ready,
    input  logic [PAY_W-1:0] dat_payload,
    input  logic [NB_W-1:0]  dat_nbytes,
    output logic             line_en,
    output logic             line_start,
    output logic             line_bit
);

    typedef struct packed {
        logic             busy;
        logic             is_data;
        logic [CNT_W-1:0] cnt;
        logic [BLK_W-1:0] sr;
        logic [SCR_W-1:0] lfsr;
    } enc_st_t;

    enc_st_t st_d, st_q;

    logic             last_bit;
    logic             can_load;
    logic             scr_on;
    logic [PAY_W-1:0] pay_masked;

    always_comb begin
        for (int b = 0; b < NBYTES; b++) begin
            if (b < int'(dat_nbytes)) pay_masked[8*b +: 8] = dat_payload[8*b +: 8];
            else                      pay_masked[8*b +: 8] = 8'h00;
        end
    end

    always_comb begin
        st_d       = st_q;
        last_bit   = st_q.busy && (st_q.cnt == CNT_W'(BLK_W - 1));
        can_load   = !st_q.busy || last_bit;
        scr_on     = st_q.busy && st_q.is_data && (st_q.cnt >= CNT_W'(HDR_W));

        ctl_ready  = can_load;
        dat_ready  = can_load && !ctl_valid;
        line_en    = st_q.busy;
        line_start = st_q.busy && (st_q.cnt == '0);
        line_bit   = st_q.sr[0] ^ (scr_on & st_q.lfsr[SCR_W-1]);

        if (st_q.busy) begin
            st_d.sr  = st_q.sr >> 1;
            st_d.cnt = st_q.cnt + 1'b1;
            if (scr_on)   st_d.lfsr = scr_step(st_q.lfsr);
            if (last_bit) st_d.busy = 1'b0;
        end

        if (can_load && ctl_valid) begin
            st_d.busy    = 1'b1;
            st_d.is_data = 1'b0;
            st_d.cnt     = '0;
            st_d.sr      = {~ctl_word, ctl_word, ~ctl_word, ctl_word, HDR_CTRL};
            if (ctl_word == SOP_WORD) st_d.lfsr = SEED;
        end else if (can_load && dat_valid) begin
            st_d.busy    = 1'b1;
            st_d.is_data = 1'b1;
            st_d.cnt     = '0;
            st_d.sr      = {pay_masked, HDR_DATA};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.busy    <= 1'b0;
            st_q.is_data <= 1'b0;
            st_q.cnt     <= '0;
            st_q.sr      <= '0;
            st_q.lfsr    <= SEED;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/blk132_dec.sv
module blk132_dec
    import blk132_pkg::*;
#(
    parameter int               CW       = 32,
    parameter logic [SCR_W-1:0] SEED     = 23'h1DBFBC,
    parameter logic [CW-1:0]    SOP_WORD = 32'hF0E1_D2C3,
    localparam int PAY_W = 4 * CW,
    localparam int BLK_W = HDR_W + PAY_W,
    localparam int CNT_W = $clog2(BLK_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             rx_start,
    input  logic             rx_bit,
    output logic             rx_valid,
    output logic             rx_is_ctrl,
    output logic             rx_err,
    output logic [PAY_W-1:0] rx_payload,
    output logic [CW-1:0]    rx_ctrl
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [BLK_W-1:0] blk;
        logic [SCR_W-1:0] lfsr;
        logic             valid;
        logic             is_ctrl;
        logic             err;
        logic [PAY_W-1:0] payload;
        logic [CW-1:0]    ctrl;
    } dec_st_t;

    dec_st_t st_d, st_q;

    logic [CNT_W-1:0] idx;
    hdr_class_e       hc;
    logic             bit_v;
    logic [BLK_W-1:0] blk_n;
    logic [PAY_W-1:0] pay_n;
    logic [CW-1:0]    w0, w1, w2, w3, vote;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        idx        = rx_start ? '0 : st_q.cnt;
        hc         = hdr_classify(st_q.blk[HDR_W-1:0]);
        bit_v      = rx_bit;
        blk_n      = st_q.blk;

        if (rx_en && (idx < CNT_W'(BLK_W))) begin
            if ((idx >= CNT_W'(HDR_W)) && (hc == HC_DATA)) begin
                bit_v     = rx_bit ^ st_q.lfsr[SCR_W-1];
                st_d.lfsr = scr_step(st_q.lfsr);
            end
            blk_n[idx] = bit_v;
            st_d.blk   = blk_n;
            st_d.cnt   = idx + 1'b1;
        end

        pay_n = blk_n[BLK_W-1:HDR_W];
        w0    = pay_n[CW-1:0];
        w1    = ~pay_n[2*CW-1:CW];
        w2    = pay_n[3*CW-1:2*CW];
        w3    = ~pay_n[4*CW-1:3*CW];
        // Ties go to copy 0: it wins with any one other copy agreeing.
        vote  = (w0 & w1) | (w0 & w2) | (w0 & w3) | (w1 & w2 & w3);

        if (rx_en && (idx == CNT_W'(BLK_W - 1))) begin
            st_d.valid   = 1'b1;
            st_d.is_ctrl = (hc == HC_CTRL);
            st_d.err     = (hc == HC_BAD);
            st_d.payload = pay_n;
            st_d.ctrl    = vote;
            if ((hc == HC_CTRL) && (vote == SOP_WORD)) st_d.lfsr = SEED;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt     <= '0;
            st_q.blk     <= '0;
            st_q.lfsr    <= SEED;
            st_q.valid   <= 1'b0;
            st_q.is_ctrl <= 1'b0;
            st_q.err     <= 1'b0;
            st_q.payload <= '0;
            st_q.ctrl    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_valid   = st_q.valid;
    assign rx_is_ctrl = st_q.is_ctrl;
    assign rx_err     = st_q.err;
    assign rx_payload = st_q.payload;
    assign rx_ctrl    = st_q.ctrl;

endmodule

// File: rtl/blk132_link.sv
module blk132_link
    import blk132_pkg::*;
#(
    parameter int               CTRL_W   = 32,
    parameter logic [SCR_W-1:0] SCR_SEED = 23'h1DBFBC,
    parameter logic [CTRL_W-1:0] SOP_WORD = 32'hF0E1_D2C3,
    localparam int PAY_W = 4 * CTRL_W,
    localparam int BLK_W = HDR_W + PAY_W,
    localparam int NB_W  = $clog2(PAY_W / 8 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_valid,
    output logic              ctl_ready,
    input  logic [CTRL_W-1:0] ctl_word,
    input  logic              dat_valid,
    output logic              dat_ready,
    input  logic [PAY_W-1:0]  dat_payload,
    input  logic [NB_W-1:0]   dat_nbytes,
    output logic              line_en,
    output logic              line_start,
    output logic              line_bit,
    input  logic              rx_en,
    input  logic              rx_start,
    input  logic              rx_bit,
    output logic              rx_valid,
    output logic              rx_is_ctrl,
    output logic              rx_err,
    output logic [PAY_W-1:0]  rx_payload,
    output logic [CTRL_W-1:0] rx_ctrl
);

    blk132_enc #(
        .CW       (CTRL_W),
        .SEED     (SCR_SEED),
        .SOP_WORD (SOP_WORD)
    ) i_enc (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_valid   (ctl_valid),
        .ctl_ready   (ctl_ready),
        .ctl_word    (ctl_word),
        .dat_valid   (dat_valid),
        .dat_ready   (dat_ready),
        .dat_payload (dat_payload),
        .dat_nbytes  (dat_nbytes),
        .line_en     (line_en),
        .line_start  (line_start),
        .line_bit    (line_bit)
    );

    blk132_dec #(
        .CW       (CTRL_W),
        .SEED     (SCR_SEED),
        .SOP_WORD (SOP_WORD)
    ) i_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .rx_start   (rx_start),
        .rx_bit     (rx_bit),
        .rx_valid   (rx_valid),
        .rx_is_ctrl (rx_is_ctrl),
        .rx_err     (rx_err),
        .rx_payload (rx_payload),
        .rx_ctrl    (rx_ctrl)
    );

endmodule

// File: rtl/blk132_link_chk.sv
module blk132_link_chk #(
    parameter int BLK_W = 132,
    parameter int PAY_W = 128,
    parameter int CW    = 32,
    localparam int IW   = $clog2(BLK_W + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_valid,
    input logic             ctl_ready,
    input logic             dat_valid,
    input logic             dat_ready,
    input logic             line_en,
    input logic             line_start,
    input logic             line_bit,
    input logic             rx_valid,
    input logic [PAY_W-1:0] rx_payload,
    input logic [CW-1:0]    rx_ctrl
);

    logic [IW-1:0] seen_q;
    logic [IW-1:0] cur_idx;

    assign cur_idx = line_start ? '0 : seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       seen_q <= '0;
        else if (line_en) seen_q <= cur_idx + 1'b1;
    end

    // R1: an idle line always accepts a control word
    p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !line_en |-> ctl_ready);

    // R2: a block is never cut short and never restarted early
    p_no_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_en && (cur_idx < IW'(BLK_W - 1))) |=> (line_en && !line_start));

    // R2: back-to-back blocks start exactly one block length apart
    p_block_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && $past(line_en)) |-> ($past(cur_idx) == IW'(BLK_W - 1)));

    // R6: an accepted control word starts a block with header bit 1
    p_ctl_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && ctl_ready) |=> (line_start && line_bit));

    // R6: an accepted data payload starts a block with header bit 0
    p_dat_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_valid && dat_ready) |=> (line_start && !line_bit));

    // R10: decoded outputs only move together with the valid pulse
    p_rx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> ($stable(rx_payload) && $stable(rx_ctrl)));

endmodule

bind blk132_link blk132_link_chk #(
    .BLK_W (BLK_W),
    .PAY_W (PAY_W),
    .CW    (CTRL_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_valid  (ctl_valid),
    .ctl_ready  (ctl_ready),
    .dat_valid  (dat_valid),
    .dat_ready  (dat_ready),
    .line_en    (line_en),
    .line_start (line_start),
    .line_bit   (line_bit),
    .rx_valid   (rx_valid),
    .rx_payload (rx_payload),
    .rx_ctrl    (rx_ctrl)
);

// File: tb/test_blk132_link.sv
module test_blk132_link;

    localparam int          CLK_PERIOD = 10;
    localparam int          BW         = 132;
    localparam logic [31:0] SOP        = 32'hF0E1_D2C3;
    localparam logic [22:0] SEED       = 23'h1DBFBC;
    localparam logic [7:0]  NONE       = 8'hFF;

    typedef struct packed {
        logic        is_ctrl;
        logic [31:0] val;
        logic [4:0]  nb;
        logic [7:0]  f1;
        logic [7:0]  f2;
        logic        exp_err;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b1, SOP,           5'd0,  NONE,  NONE,  1'b0}, // reseed
        '{1'b0, 32'h1234_5678, 5'd16, NONE,  NONE,  1'b0}, // full data
        '{1'b0, 32'h0BAD_F00D, 5'd5,  NONE,  NONE,  1'b0}, // R5 partial fill
        '{1'b0, 32'hDEAD_BEEF, 5'd0,  NONE,  NONE,  1'b0}, // R5 empty payload
        '{1'b0, 32'h2468_ACE0, 5'd16, 8'd41, NONE,  1'b0}, // R10 one payload flip
        '{1'b0, 32'h7777_1111, 5'd16, 8'd2,  NONE,  1'b0}, // R7 data header 1 flip
        '{1'b1, 32'hCAFE_0001, 5'd0,  8'd0,  8'd39, 1'b0}, // R7 hdr flip + R9 copy1 flip
        '{1'b1, 32'h00FF_00FF, 5'd0,  8'd9,  8'd73, 1'b0}, // R9 tie, copies 0 and 2 wrong
        '{1'b1, 32'h1357_2468, 5'd0,  8'd0,  8'd3,  1'b1}, // R8 ctrl header 2 flips
        '{1'b0, 32'h9999_AAAA, 5'd16, 8'd1,  8'd2,  1'b1}, // R8 data header 2 flips
        '{1'b1, SOP,           5'd0,  NONE,  NONE,  1'b0}, // resync
        '{1'b0, 32'hFFFF_FFFF, 5'd16, NONE,  NONE,  1'b0},
        '{1'b0, 32'h3C3C_5A5A, 5'd17, NONE,  NONE,  1'b0}, // R5 count above 16
        '{1'b1, 32'h0000_0001, 5'd0,  NONE,  NONE,  1'b0}, // R4 scrambler holds
        '{1'b0, 32'h55AA_55AA, 5'd16, NONE,  NONE,  1'b0}
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         ctl_valid, ctl_ready;
    logic [31:0]  ctl_word;
    logic         dat_valid, dat_ready;
    logic [127:0] dat_payload;
    logic [4:0]   dat_nbytes;
    logic         line_en, line_start, line_bit;
    logic         rx_en, rx_start, rx_bit;
    logic         rx_valid, rx_is_ctrl, rx_err;
    logic [127:0] rx_payload;
    logic [31:0]  rx_ctrl;

    always #(CLK_PERIOD / 2) clk = ~clk;

    blk132_link i_blk132_link (
        .clk(clk), .rst_n(rst_n),
        .ctl_valid(ctl_valid), .ctl_ready(ctl_ready), .ctl_word(ctl_word),
        .dat_valid(dat_valid), .dat_ready(dat_ready),
        .dat_payload(dat_payload), .dat_nbytes(dat_nbytes),
        .line_en(line_en), .line_start(line_start), .line_bit(line_bit),
        .rx_en(rx_en), .rx_start(rx_start), .rx_bit(rx_bit),
        .rx_valid(rx_valid), .rx_is_ctrl(rx_is_ctrl), .rx_err(rx_err),
        .rx_payload(rx_payload), .rx_ctrl(rx_ctrl)
    );

    // Loopback with error injection
    logic [7:0]   tb_idx;
    logic [7:0]   cur_idx;
    logic [131:0] inj_mask;
    logic         flip;

    assign cur_idx  = line_start ? 8'd0 : tb_idx;
    assign flip     = line_en && (cur_idx < 8'd132) && inj_mask[cur_idx];
    assign rx_en    = line_en;
    assign rx_start = line_start;
    assign rx_bit   = line_bit ^ flip;

    always @(posedge clk) begin
        if (!rst_n)       tb_idx <= 8'd0;
        else if (line_en) tb_idx <= cur_idx + 8'd1;
    end

    // Monitor: captured line blocks and decoded results
    logic [131:0] cap_cur;
    logic [131:0] cap_blk [32];
    int           st_cyc  [32];
    logic [127:0] got_pay [32];
    logic [31:0]  got_ctl [32];
    logic         got_err [32];
    logic         got_isc [32];
    int           cap_n = 0;
    int           rx_n  = 0;
    int           cyc   = 0;

    always @(negedge clk) begin
        logic [131:0] t;
        cyc = cyc + 1;
        if (rst_n && line_en && cap_n < 32) begin
            t = cap_cur;
            t[cur_idx] = line_bit;
            cap_cur = t;
            if (line_start) st_cyc[cap_n] = cyc;
            if (cur_idx == 8'd131) begin
                cap_blk[cap_n] = t;
                cap_n = cap_n + 1;
            end
        end
        if (rst_n && rx_valid && rx_n < 32) begin
            got_pay[rx_n] = rx_payload;
            got_ctl[rx_n] = rx_ctrl;
            got_err[rx_n] = rx_err;
            got_isc[rx_n] = rx_is_ctrl;
            rx_n = rx_n + 1;
        end
    end

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic chk(input string tag, input logic [131:0] act, input logic [131:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model from the requirements
    logic [22:0] m_lfsr = SEED;

    function automatic logic [22:0] m_step(input logic [22:0] s);
        return {s[21:0], s[22] ^ s[20] ^ s[15] ^ s[7] ^ s[5] ^ s[1]};
    endfunction

    function automatic logic [127:0] mk_pay(input logic [31:0] v);
        return {v ^ 32'h5A5A_C3C3, ~v, v[15:0], v[31:16], v};
    endfunction

    task automatic model(input logic c, input logic [31:0] v, input logic [4:0] nb,
                         output logic [131:0] blk, output logic [127:0] clr);
        logic [127:0] p;
        p = mk_pay(v);
        for (int b = 0; b < 16; b++) if (b >= int'(nb)) p[8*b +: 8] = 8'h00;
        blk = '0;
        if (c) begin
            blk = {~v, v, ~v, v, 4'b0011};
            clr = {~v, v, ~v, v};
            if (v == SOP) m_lfsr = SEED;
        end else begin
            clr = p;
            blk[3:0] = 4'b1100;
            for (int i = 0; i < 128; i++) begin
                blk[4+i] = p[i] ^ m_lfsr[22];
                m_lfsr   = m_step(m_lfsr);
            end
        end
    endtask

    // Vote of four copies: three or more agree, else copy 0 decides a tie
    function automatic logic [31:0] vote4(input logic [131:0] b);
        logic [31:0] r;
        logic [31:0] c0, c1, c2, c3;
        int ones;
        c0 = b[35:4]; c1 = ~b[67:36]; c2 = b[99:68]; c3 = ~b[131:100];
        for (int k = 0; k < 32; k++) begin
            ones = int'(c0[k]) + int'(c1[k]) + int'(c2[k]) + int'(c3[k]);
            r[k] = (ones >= 3) || ((ones == 2) && c0[k]);
        end
        return r;
    endfunction

    task automatic wait_rx(input int target);
        int guard;
        guard = 0;
        while (rx_n < target && guard < 2000) begin
            @(posedge clk);
            guard++;
        end
        if (rx_n < target) chk("R10 decode timeout", 132'(rx_n), 132'(target));
    endtask

    task automatic send(input logic c, input logic [31:0] v, input logic [4:0] nb);
        @(negedge clk);
        if (c) begin ctl_word = v; ctl_valid = 1'b1; end
        else begin dat_payload = mk_pay(v); dat_nbytes = nb; dat_valid = 1'b1; end
        #1;
        while (!(c ? ctl_ready : dat_ready)) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        ctl_valid = 1'b0;
        dat_valid = 1'b0;
    endtask

    task automatic run_vec(input vec_t vv);
        logic [131:0] eb;
        logic [127:0] ec;
        int n0, c0;
        n0 = rx_n; c0 = cap_n;
        inj_mask = '0;
        if (vv.f1 != NONE) inj_mask[vv.f1] = 1'b1;
        if (vv.f2 != NONE) inj_mask[vv.f2] = 1'b1;
        model(vv.is_ctrl, vv.val, vv.nb, eb, ec);
        send(vv.is_ctrl, vv.val, vv.nb);
        wait_rx(n0 + 1);
        if (vv.is_ctrl) chk("R2 R3 control line block", cap_blk[c0], eb);
        else            chk("R2 R4 R5 data line block", cap_blk[c0], eb);
        chk("R8 error flag", 132'(got_err[n0]), 132'(vv.exp_err));
        if (!vv.exp_err) begin
            chk("R7 block class", 132'(got_isc[n0]), 132'(vv.is_ctrl));
            if (vv.is_ctrl) chk("R9 voted word", 132'(got_ctl[n0]), 132'(vote4(eb ^ inj_mask)));
            else            chk("R10 descrambled payload", 132'(got_pay[n0]), 132'(ec ^ inj_mask[131:4]));
        end else begin
            chk("R8 class cleared", 132'(got_isc[n0]), 132'(0));
        end
        inj_mask = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [131:0] eb0, eb1;
        logic [127:0] ec0, ec1;
        int n0, c0;

        rst_n = 1'b0; ctl_valid = 1'b0; dat_valid = 1'b0;
        ctl_word = '0; dat_payload = '0; dat_nbytes = '0; inj_mask = '0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R1 line idle", 132'(line_en), 132'(0));
        chk("R1 rx_valid low", 132'(rx_valid), 132'(0));
        chk("R1 ctl_ready", 132'(ctl_ready), 132'(1));
        chk("R1 dat_ready", 132'(dat_ready), 132'(1));
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R1: a data block straight after reset uses the seed
        run_vec('{1'b0, 32'hA1B2_C3D4, 5'd16, NONE, NONE, 1'b0});

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R6: simultaneous requests, control first, then data with no gap
        n0 = rx_n; c0 = cap_n;
        model(1'b1, 32'h0F0F_1234, 5'd0, eb0, ec0);
        model(1'b0, 32'h8421_1248, 5'd16, eb1, ec1);
        @(negedge clk);
        ctl_word = 32'h0F0F_1234; ctl_valid = 1'b1;
        dat_payload = mk_pay(32'h8421_1248); dat_nbytes = 5'd16; dat_valid = 1'b1;
        #1;
        chk("R6 data held off by control", 132'(dat_ready), 132'(0));
        chk("R6 control ready when idle", 132'(ctl_ready), 132'(1));
        @(posedge clk);
        @(negedge clk);
        ctl_valid = 1'b0;
        #1;
        chk("R6 not ready mid-block", 132'(dat_ready), 132'(0));
        while (!dat_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        dat_valid = 1'b0;
        wait_rx(n0 + 2);
        chk("R6 block spacing", 132'(st_cyc[c0 + 1] - st_cyc[c0]), 132'(BW));
        chk("R6 R3 first block", cap_blk[c0], eb0);
        chk("R6 R4 second block", cap_blk[c0 + 1], eb1);
        chk("R6 R9 first decode", 132'(got_ctl[n0]), 132'(32'h0F0F_1234));
        chk("R6 R10 second decode", 132'(got_pay[n0 + 1]), 132'(ec1));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule